// File: doc/BRIEF.md
# Display RAM Write Address Generator

This block sits between a host command decoder and a display data RAM of 128 columns by 9 byte-rows. Rows 0 to 7 hold full bytes of eight vertical pixels. Row 8 is a one-bit icon row. For each host write strobe, the block produces one registered RAM write. The write carries the physical column, the row and the data to store. The block then advances its internal X (column) and Y (row) pointers.

Three mode bits control the writes:
- **Increment direction.** X runs first (horizontal) or Y runs first (vertical).
- **Column mirroring.** Logical column 0 maps to the left or to the right physical column.
- **Bit order.** The byte is stored as given or bit-reversed.

The host can load either pointer directly. A loaded value that is out of range is replaced by 0. Host bus decoding, display readout and the RAM array itself are outside the block.

Top module: `disp_wr_addr_gen`

## Requirements
- R1: After reset the outputs are zero with `ram_we_o` low, the pointers are (X=0, Y=0), and all three mode bits are 0. The first write therefore goes to column 0, row 0, with the data unchanged.
- R2: A strobe on `wr_i` sampled at a clock edge makes `ram_we_o` high for exactly the following cycle. In that same cycle `ram_col_o`, `ram_row_o` and `ram_data_o` are valid. With no strobe, `ram_we_o` is low.
- R3: With `vert` = 0, X increments after each write. A write at X=127 sets X to 0 and moves Y to the next row.
- R4: With `vert` = 1, Y increments after each write. A write at Y=8 sets Y to 0 and moves X to the next column.
- R5: A write at (X=127, Y=8) sends both pointers to (0, 0), in either direction mode.
- R6: With `mirror` = 1 the physical column is 127 − X. With `mirror` = 0 the physical column is X.
- R7: With `rev` = 1, input bit i is stored at bit 7−i. With `rev` = 0 the byte is stored unchanged.
- R8: In row 8 only bit 0 of the byte is stored, taken after any reversal. Output bits 7..1 are 0.
- R9: `set_x_i` loads X from `x_i` and `set_y_i` loads Y from `y_i`. A Y value above 8, or an X value of 128 or more, loads 0.
- R10: If a load and a write fall in the same cycle, the write uses the old pointers. The loaded pointer takes the loaded value. The other pointer takes its normal advanced value.
- R11: `set_mode_i` loads the mode bits `{vert_i, mirror_i, rev_i}`, and they apply from the next write on. A write in the same cycle uses the old modes. Without a write or a load, both pointers hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host data write strobe |
| data_i | input | 8 | Host data byte |
| set_x_i | input | 1 | Load the X pointer |
| x_i | input | 7 | X value to load |
| set_y_i | input | 1 | Load the Y pointer |
| y_i | input | 4 | Y value to load |
| set_mode_i | input | 1 | Load the mode bits |
| vert_i | input | 1 | Direction: 0 = X first, 1 = Y first |
| mirror_i | input | 1 | Column mirroring |
| rev_i | input | 1 | Bit-reverse stored bytes |
| ram_we_o | output | 1 | RAM write enable, registered |
| ram_col_o | output | 7 | Physical RAM column |
| ram_row_o | output | 4 | RAM row (8 = icon row) |
| ram_data_o | output | 8 | Data to store |

## Verification
A host write and a pointer or mode load can fall in the same cycle. The bench provokes this by raising `wr_i` together with `set_x_i`, `set_y_i` or `set_mode_i` on one edge. One case places the write at X=127, so that the auto-increment would also wrap into the loaded axis.

Each case is judged twice:
- **The colliding write.** It must land at the old address with the old modes.
- **The next write.** It must land at the loaded value on the loaded axis, and at the advanced value on the other axis.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;
  typedef struct packed {
    logic vert;
    logic mirror;
    logic rev;
  } wr_mode_t;
endpackage

// File: rtl/dwag_mode_reg.sv
module dwag_mode_reg
  import disp_wr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ld_i,
  input  wr_mode_t mode_i,
  output wr_mode_t mode_o
);
  wr_mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (ld_i) mode_q <= mode_i;
  end

  assign mode_o = mode_q;

  assert_mode_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(mode_q));
endmodule

// File: rtl/dwag_ptr.sv
module dwag_ptr #(
  parameter int NUM_COLS = 128,
  parameter int NUM_ROWS = 9,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             vert_i,
  input  logic             ld_x_i,
  input  logic [COL_W-1:0] x_i,
  input  logic             ld_y_i,
  input  logic [ROW_W-1:0] y_i,
  output logic [COL_W-1:0] x_o,
  output logic [ROW_W-1:0] y_o
);
  localparam logic [COL_W-1:0] MAX_X = COL_W'(NUM_COLS - 1);
  localparam logic [ROW_W-1:0] MAX_Y = ROW_W'(NUM_ROWS - 1);

  logic [COL_W-1:0] x_q, x_d;
  logic [ROW_W-1:0] y_q, y_d;
  logic x_end, y_end;

  assign x_end = (x_q == MAX_X);
  assign y_end = (y_q == MAX_Y);

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (adv_i) begin
      if (!vert_i) begin
        x_d = x_end ? '0 : x_q + COL_W'(1);
        if (x_end) y_d = y_end ? '0 : y_q + ROW_W'(1);
      end else begin
        y_d = y_end ? '0 : y_q + ROW_W'(1);
        if (y_end) x_d = x_end ? '0 : x_q + COL_W'(1);
      end
    end
    // loads win over auto-increment; out-of-range clamps to 0
    if (ld_x_i) x_d = (int'(x_i) >= NUM_COLS) ? '0 : x_i;
    if (ld_y_i) y_d = (int'(y_i) >= NUM_ROWS) ? '0 : y_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  assert_x_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !ld_x_i |=> $stable(x_q));
  assert_y_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !ld_y_i |=> $stable(y_q));
  assert_y_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(y_q) < NUM_ROWS);
  assert_h_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !vert_i && !ld_x_i && !x_end |=> x_q == $past(x_q) + COL_W'(1));
  assert_v_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && vert_i && !ld_y_i && !y_end |=> y_q == $past(y_q) + ROW_W'(1));
  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ld_x_i && !ld_y_i && x_end && y_end |=> x_q == '0 && y_q == '0);
endmodule

// File: rtl/dwag_map.sv
module dwag_map #(
  parameter int NUM_COLS = 128,
  parameter int NUM_ROWS = 9,
  parameter int DATA_W   = 8,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic [COL_W-1:0]  x_i,
  input  logic [ROW_W-1:0]  y_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mirror_i,
  input  logic              rev_i,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [COL_W-1:0] MAX_X    = COL_W'(NUM_COLS - 1);
  localparam logic [ROW_W-1:0] ICON_ROW = ROW_W'(NUM_ROWS - 1);

  logic [DATA_W-1:0] rev_data, sel_data;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_data[i] = data_i[DATA_W-1-i];
  end

  assign sel_data = rev_i ? rev_data : data_i;
  assign col_o    = mirror_i ? (MAX_X - x_i) : x_i;
  assign row_o    = y_i;

  always_comb begin
    data_o = sel_data;
    if (y_i == ICON_ROW) begin
      data_o    = '0;
      data_o[0] = sel_data[0];
    end
  end
endmodule

// File: rtl/disp_wr_addr_gen.sv
module disp_wr_addr_gen
  import disp_wr_pkg::*;
#(
  parameter int NUM_COLS = 128,
  parameter int NUM_ROWS = 9,
  parameter int DATA_W   = 8,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              set_x_i,
  input  logic [COL_W-1:0]  x_i,
  input  logic              set_y_i,
  input  logic [ROW_W-1:0]  y_i,
  input  logic              set_mode_i,
  input  logic              vert_i,
  input  logic              mirror_i,
  input  logic              rev_i,
  output logic              ram_we_o,
  output logic [COL_W-1:0]  ram_col_o,
  output logic [ROW_W-1:0]  ram_row_o,
  output logic [DATA_W-1:0] ram_data_o
);
  localparam logic [COL_W-1:0] MAX_X    = COL_W'(NUM_COLS - 1);
  localparam logic [ROW_W-1:0] ICON_ROW = ROW_W'(NUM_ROWS - 1);

  wr_mode_t          mode, mode_in;
  logic [COL_W-1:0]  x_cur, col_map;
  logic [ROW_W-1:0]  y_cur, row_map;
  logic [DATA_W-1:0] data_map;

  assign mode_in = '{vert: vert_i, mirror: mirror_i, rev: rev_i};

  dwag_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (set_mode_i),
    .mode_i (mode_in),
    .mode_o (mode)
  );

  dwag_ptr #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (wr_i),
    .vert_i (mode.vert),
    .ld_x_i (set_x_i),
    .x_i    (x_i),
    .ld_y_i (set_y_i),
    .y_i    (y_i),
    .x_o    (x_cur),
    .y_o    (y_cur)
  );

  dwag_map #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)) u_map (
    .x_i      (x_cur),
    .y_i      (y_cur),
    .data_i   (data_i),
    .mirror_i (mode.mirror),
    .rev_i    (mode.rev),
    .col_o    (col_map),
    .row_o    (row_map),
    .data_o   (data_map)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_we_o   <= 1'b0;
      ram_col_o  <= '0;
      ram_row_o  <= '0;
      ram_data_o <= '0;
    end else begin
      ram_we_o <= wr_i;
      if (wr_i) begin
        ram_col_o  <= col_map;
        ram_row_o  <= row_map;
        ram_data_o <= data_map;
      end
    end
  end

  assert_we_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o == $past(wr_i));
  assert_mirror_col_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && mode.mirror |=> ram_col_o == MAX_X - $past(x_cur));
  assert_icon_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o && ram_row_o == ICON_ROW |-> ram_data_o[DATA_W-1:1] == '0);
endmodule

// File: tb/tb_disp_wr_addr_gen.sv
`timescale 1ns/1ps
module tb_disp_wr_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, set_x = 1'b0, set_y = 1'b0, set_mode = 1'b0;
  logic [7:0] data = '0;
  logic [6:0] x_in = '0;
  logic [3:0] y_in = '0;
  logic       vert = 1'b0, mirror = 1'b0, rev = 1'b0;
  logic       we;
  logic [6:0] col;
  logic [3:0] row;
  logic [7:0] dout;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disp_wr_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .data_i(data),
    .set_x_i(set_x), .x_i(x_in), .set_y_i(set_y), .y_i(y_in),
    .set_mode_i(set_mode), .vert_i(vert), .mirror_i(mirror), .rev_i(rev),
    .ram_we_o(we), .ram_col_o(col), .ram_row_o(row), .ram_data_o(dout)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_xy(input int x, input int y);
    @(negedge clk);
    set_x = 1'b1; x_in = 7'(x); set_y = 1'b1; y_in = 4'(y);
    @(negedge clk);
    set_x = 1'b0; set_y = 1'b0;
  endtask

  task automatic set_md(input bit v, input bit m, input bit r);
    @(negedge clk);
    set_mode = 1'b1; vert = v; mirror = m; rev = r;
    @(negedge clk);
    set_mode = 1'b0;
  endtask

  task automatic wr_chk(input string req, input int d, input int ec, input int er, input int ed);
    @(negedge clk);
    wr = 1'b1; data = 8'(d);
    @(negedge clk);
    wr = 1'b0;
    chk({req, " we"}, int'(we), 1);
    chk({req, " col"}, int'(col), ec);
    chk({req, " row"}, int'(row), er);
    chk({req, " data"}, int'(dout), ed);
  endtask

  task automatic t_reset();
    chk("R1 we", int'(we), 0);
    chk("R1 col", int'(col), 0);
    chk("R1 data", int'(dout), 0);
    wr_chk("R1", 8'hA5, 0, 0, 8'hA5);
    @(negedge clk);
    chk("R2 we drop", int'(we), 0);
  endtask

  task automatic t_horiz();
    set_md(0, 0, 0);
    set_xy(126, 0);
    wr_chk("R3", 8'h11, 126, 0, 8'h11);
    wr_chk("R3", 8'h22, 127, 0, 8'h22);
    wr_chk("R3 wrap row", 8'h33, 0, 1, 8'h33);
  endtask

  task automatic t_vert();
    set_md(1, 0, 0);
    set_xy(5, 7);
    wr_chk("R4", 8'h44, 5, 7, 8'h44);
    wr_chk("R4 icon", 8'h45, 5, 8, 8'h01);
    wr_chk("R4 wrap col", 8'h46, 6, 0, 8'h46);
  endtask

  task automatic t_wrap();
    set_md(0, 0, 0);
    set_xy(127, 8);
    wr_chk("R5 h last", 8'h00, 127, 8, 0);
    wr_chk("R5 h zero", 8'h5A, 0, 0, 8'h5A);
    set_md(1, 0, 0);
    set_xy(127, 8);
    wr_chk("R5 v last", 8'h00, 127, 8, 0);
    wr_chk("R5 v zero", 8'h5B, 0, 0, 8'h5B);
  endtask

  task automatic t_mirror();
    set_md(0, 1, 0);
    set_xy(0, 3);
    wr_chk("R6", 8'h12, 127, 3, 8'h12);
    set_xy(10, 3);
    wr_chk("R6", 8'h13, 117, 3, 8'h13);
    set_md(0, 0, 0);
    set_xy(10, 3);
    wr_chk("R6 off", 8'h14, 10, 3, 8'h14);
  endtask

  task automatic t_rev();
    set_md(0, 0, 1);
    set_xy(20, 2);
    wr_chk("R7", 8'h01, 20, 2, 8'h80);
    wr_chk("R7", 8'hC1, 21, 2, 8'h83);
    wr_chk("R7", 8'h3C, 22, 2, 8'h3C);
  endtask

  task automatic t_icon();
    set_md(0, 0, 0);
    set_xy(40, 8);
    wr_chk("R8", 8'hFE, 40, 8, 8'h00);
    wr_chk("R8", 8'hFF, 41, 8, 8'h01);
    set_md(0, 0, 1);
    wr_chk("R8 rev", 8'h80, 42, 8, 8'h01);
  endtask

  task automatic t_set();
    set_md(0, 0, 0);
    set_xy(64, 12);
    wr_chk("R9 clamp", 8'h21, 64, 0, 8'h21);
    set_xy(3, 8);
    wr_chk("R9 load", 8'h22, 3, 8, 8'h00);
  endtask

  task automatic t_collide();
    set_md(0, 0, 0);
    set_xy(10, 2);
    @(negedge clk);
    wr = 1'b1; data = 8'h61; set_x = 1'b1; x_in = 7'd50;
    @(negedge clk);
    wr = 1'b0; set_x = 1'b0;
    chk("R10 old col", int'(col), 10);
    chk("R10 old row", int'(row), 2);
    wr_chk("R10 loaded", 8'h62, 50, 2, 8'h62);
    set_xy(127, 2);
    @(negedge clk);
    wr = 1'b1; data = 8'h63; set_y = 1'b1; y_in = 4'd5;
    @(negedge clk);
    wr = 1'b0; set_y = 1'b0;
    chk("R10 old col", int'(col), 127);
    wr_chk("R10 y wins", 8'h64, 0, 5, 8'h64);
  endtask

  task automatic t_mode_same();
    set_md(0, 0, 0);
    set_xy(30, 4);
    @(negedge clk);
    wr = 1'b1; data = 8'h01; set_mode = 1'b1; vert = 0; mirror = 1; rev = 1;
    @(negedge clk);
    wr = 1'b0; set_mode = 1'b0;
    chk("R11 old mirror", int'(col), 30);
    chk("R11 old rev", int'(dout), 8'h01);
    repeat (5) @(negedge clk);
    chk("R11 idle we", int'(we), 0);
    wr_chk("R11 new mode", 8'h01, 127 - 31, 4, 8'h80);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_horiz();
    t_vert();
    t_wrap();
    t_mirror();
    t_rev();
    t_icon();
    t_set();
    t_collide();
    t_mode_same();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule